// File: doc/BRIEF.md
# Saturating Error Counter with Byte Readout

The block accumulates a per-cycle count of received bit errors into a 24-bit counter. Software reads it through a byte-wide register interface: a read strobe with a small byte address returns one byte of the count on the next clock edge. The three count bytes are read one at a time, but the block hands software one consistent 24-bit value.

Software reads the most significant byte first. That read copies the whole live count into a snapshot register and restarts the live counter from the errors that arrive in that same cycle, so no error is lost or counted twice. Software then reads the middle and low bytes from the snapshot, and the low-byte read empties the snapshot. The counter stops at its all-ones value instead of wrapping. While the enable input is low, the count and the snapshot both stay at zero.

Top module: `sec_err_counter`

## Requirements
- R1: After reset the live count, the snapshot and `rd_data_o` are all zero.
- R2: While `cnt_en_i` is high, each clock edge adds the value on `err_inc_i` (an unsigned count, default 4 bits) to the live count.
- R3: The live count saturates at 0xFFFFFF and stays there under further errors; it never rolls over to zero.
- R4: A read at address 0 returns bits 23:16 of the live count. In the same edge it copies the full live count into the snapshot.
- R5: A read at address 1 returns bits 15:8 of the snapshot, and a read at address 2 returns bits 7:0 of the snapshot. Errors counted after the address-0 read do not change either value.
- R6: A read at address 2 clears the snapshot, so later reads at addresses 1 and 2 return 0x00 until the next address-0 read.
- R7: While `cnt_en_i` is low, the live count and the snapshot are held at zero, errors are ignored, and every read returns 0x00.
- R8: A read at address 3 returns 0x00 and changes neither the live count nor the snapshot.
- R9: `rd_data_o` changes only on the clock edge that follows a cycle with `rd_en_i` high, and it holds its value in every other cycle.
- R10: An address-0 read clears the live count. The errors presented in the same cycle as that read become the new live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_inc_i | input | INC_W | Number of bit errors seen this cycle |
| cnt_en_i | input | 1 | Count enable; low holds the count at zero |
| rd_en_i | input | 1 | Register read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Byte address: 0 high, 1 middle, 2 low, 3 unused |
| rd_data_o | output | 8 | Registered read data |

## Verification
An error value presented in a cycle enters the live count at the next rising edge. A read strobe produces its byte on `rd_data_o` at that same edge, and an address-0 read captures the count as it stood before that edge. The bench drives every input on the falling edge and samples `rd_data_o` on the following falling edge, half a cycle after the result is due. Errors driven in the same cycle as an address-0 read are therefore expected in the next snapshot and not in the current one. The bench widens the increment port so that saturation is reached within a few hundred cycles.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] rd_byte_t;
endpackage

// File: rtl/sec_sat_add.sv
module sec_sat_add #(
  parameter int unsigned A_W = 24,
  parameter int unsigned B_W = 4
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] sum_o
);
  localparam int unsigned S_W = A_W + 1;

  logic [S_W-1:0] full_sum;

  assign full_sum = {1'b0, a_i} + S_W'(b_i);
  // carry out means overflow: clamp to all ones
  assign sum_o = full_sum[A_W] ? '1 : full_sum[A_W-1:0];
endmodule

// File: rtl/sec_live_cnt.sv
module sec_live_cnt #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             snap_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, add_base, add_sum;

  // a snapshot restarts from zero but keeps this cycle's errors
  assign add_base = snap_i ? '0 : cnt_q;

  sec_sat_add #(.A_W(CNT_W), .B_W(INC_W)) u_add (
    .a_i   (add_base),
    .b_i   (inc_i),
    .sum_o (add_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= add_sum;
  end

  assign cnt_o = cnt_q;

  p_grow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !snap_i |=> cnt_q >= $past(cnt_q));
  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !snap_i && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  p_off_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  p_keep_snap_errs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && snap_i |=> cnt_q == CNT_W'($past(inc_i)));
endmodule

// File: rtl/sec_readout.sv
module sec_readout
  import sec_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  live_i,
  output logic              snap_o,
  output rd_byte_t          rd_data_o
);
  localparam int unsigned NUM_BYTES = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

  logic [CNT_W-1:0] shadow_q;
  rd_byte_t         shadow_byte [NUM_BYTES];
  rd_byte_t         sel_byte, rd_data_q;
  logic             last_rd;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bytes
    assign shadow_byte[g] = shadow_q[(NUM_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  assign snap_o  = rd_en_i && (rd_addr_i == '0);
  assign last_rd = rd_en_i && (rd_addr_i == LAST_ADDR);

  always_comb begin
    sel_byte = '0;
    if (en_i) begin
      if (rd_addr_i == '0) begin
        sel_byte = live_i[CNT_W-1 -: BYTE_W];
      end else begin
        for (int k = 1; k < NUM_BYTES; k++)
          if (rd_addr_i == ADDR_W'(k)) sel_byte = shadow_byte[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (!en_i)   shadow_q <= '0;
    else if (snap_o)  shadow_q <= live_i;
    else if (last_rd) shadow_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= sel_byte;
  end

  assign rd_data_o = rd_data_q;

  p_snapshot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && snap_o |=> shadow_q == $past(live_i));
  p_last_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && last_rd |=> shadow_q == '0);
  p_off_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> shadow_q == '0 && rd_data_o == '0 || !$past(rd_en_i));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/sec_err_counter.sv
module sec_err_counter #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned INC_W  = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INC_W-1:0]  err_inc_i,
  input  logic              cnt_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [CNT_W-1:0] live_cnt;
  logic             snap;

  sec_live_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en_i),
    .snap_i (snap),
    .inc_i  (err_inc_i),
    .cnt_o  (live_cnt)
  );

  sec_readout #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cnt_en_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .live_i    (live_cnt),
    .snap_o    (snap),
    .rd_data_o (rd_data_o)
  );

  p_addr3_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == 2'd3 |=> rd_data_o == 8'h00);
endmodule

// File: tb/sec_err_counter_bench.sv
module sec_err_counter_bench;
  localparam int unsigned INC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [INC_W-1:0] err_inc = '0;
  logic             cnt_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [1:0]       rd_addr = '0;
  logic [7:0]       rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_err_counter #(.CNT_W(24), .INC_W(INC_W), .ADDR_W(2)) u_sec_err_counter (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .err_inc_i (err_inc),
    .cnt_en_i  (cnt_en),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one read strobe, optional errors in the same cycle; returns byte after edge
  task automatic rd(input logic [1:0] a, input logic [INC_W-1:0] inc, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; err_inc = inc;
    @(negedge clk);
    rd_en = 1'b0; err_inc = '0;
    d = rd_data;
  endtask

  task automatic add(input logic [INC_W-1:0] inc, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      err_inc = inc;
    end
    @(negedge clk);
    err_inc = '0;
  endtask

  task automatic rd3(input string tag, input logic [23:0] exp);
    logic [7:0] d;
    rd(2'd0, '0, d); chk({tag, " R4 hi"}, d, exp[23:16]);
    rd(2'd1, '0, d); chk({tag, " R5 mid"}, d, exp[15:8]);
    rd(2'd2, '0, d); chk({tag, " R5 lo"}, d, exp[7:0]);
  endtask

  task automatic t_reset;
    chk("R1 data after reset", rd_data, 8'h00);
    cnt_en = 1'b1;
    rd3("R1 count after reset", 24'h0);
  endtask

  task automatic t_accum;
    add(16'h1234, 1);
    add(16'h5678, 1);
    add(16'h0001, 1);
    rd3("R2 accumulate", 24'h0068AD);
    add(16'hFFFF, 3);
    rd3("R2 multi-cycle", 24'h02FFFD);
  endtask

  task automatic t_coherent;
    logic [7:0] d;
    add(16'hFFFF, 2);                 // 0x01FFFE
    rd(2'd0, 16'h0022, d);
    chk("R4 hi of snapshot", d, 8'h01);
    add(16'h0100, 2);                 // live now 0x222
    rd(2'd1, '0, d); chk("R5 mid ignores later errors", d, 8'hFF);
    rd(2'd2, '0, d); chk("R5 lo ignores later errors", d, 8'hFE);
    rd(2'd1, '0, d); chk("R6 mid after clear", d, 8'h00);
    rd(2'd2, '0, d); chk("R6 lo after clear", d, 8'h00);
    rd3("R10 errors in snapshot cycle kept", 24'h000222);
  endtask

  task automatic t_addr3;
    logic [7:0] d;
    add(16'h0ABC, 1);
    rd(2'd3, '0, d); chk("R8 addr3 reads zero", d, 8'h00);
    rd3("R8 addr3 no side effect", 24'h000ABC);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    add(16'h0345, 1);
    rd(2'd0, '0, d);
    rd(2'd1, '0, d); chk("R9 mid read", d, 8'h03);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      err_inc = 16'h0077;
      chk("R9 data holds while idle", rd_data, 8'h03);
    end
    @(negedge clk);
    err_inc = '0;
    chk("R9 data holds while idle", rd_data, 8'h03);
    rd(2'd2, '0, d); chk("R9 lo read", d, 8'h45);
  endtask

  task automatic t_enable;
    logic [7:0] d;
    rd(2'd0, '0, d);                  // drain live count
    rd(2'd2, '0, d);
    add(16'h0500, 1);
    @(negedge clk);
    cnt_en = 1'b0;
    add(16'h0077, 2);
    rd(2'd0, '0, d); chk("R7 hi read while disabled", d, 8'h00);
    rd(2'd1, '0, d); chk("R7 mid read while disabled", d, 8'h00);
    @(negedge clk);
    cnt_en = 1'b1;
    rd3("R7 count cleared by disable", 24'h0);
  endtask

  task automatic t_saturate;
    add(16'hFFFF, 257);
    rd3("R3 saturate", 24'hFFFFFF);
    add(16'hFFFF, 257);
    add(16'h0005, 3);
    rd3("R3 stays saturated", 24'hFFFFFF);
    rd3("R3 restart after read", 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accum();
    t_coherent();
    t_addr3();
    t_hold();
    t_enable();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule